// File: doc/BRIEF.md
# Clocked Parallel EEPROM Page-Write Device

This block models the device side of a byte-wide parallel EEPROM whose pins are sampled by a system clock. A host drives a 15-bit address, active-low chip select, output enable and write enable, and an 8-bit data bus. The bus is modelled as separate input, output and output-enable signals. A write-inhibit input stands in for a low-supply detector. Reads behave like a static RAM. Writes are collected into a page buffer of up to `PAGE_BYTES` bytes that share one page. The buffer is then committed to the storage array by an internally timed programming cycle.

The strobes, address and data all pass through the same two-flop pipeline, so every decision lags the pins by two clock cycles. A write cycle opens when chip select and write enable are both low while output enable is high. The address is taken when that condition starts, which is at the later of the two falling strobes. The data is taken when it ends, which is at the earlier of the two rising strobes. Each accepted byte restarts a load window of `LOAD_WINDOW` idle cycles. When the window runs out, programming runs for `PROG_CYCLES` cycles. During programming, reads return polling status in place of array data.

The array holds `ARRAY_BYTES` bytes and resets to all ones, which stands for the erased state. Address bits above the array size alias. The page-match rule always uses the full address.

Top module: `eep_page_device`

## Requirements
- R1: With chip select and output enable low and write enable high, `busDataOe` is 1 and `busDataOut` shows the byte at the address, two cycles after the pins. After reset every byte reads 8'hFF.
- R2: `busDataOe` is 0 whenever chip select or output enable was high two cycles earlier.
- R3: A write cycle exists only while chip select and write enable are low with output enable high. A write-enable pulse taken while output enable is low stores nothing.
- R4: The written address is the one present when the later of the two strobes falls. The written data is the value present when the earlier of the two strobes rises.
- R5: Bytes written within one page, with gaps shorter than the load window, are programmed together. A repeated address keeps its last value. Bytes that were not loaded keep their old contents.
- R6: A write whose address bits 14..6 differ from the open page's discards the whole load, so nothing is programmed.
- R7: Programming starts only after `LOAD_WINDOW` idle cycles following the last accepted byte, and lasts exactly `PROG_CYCLES` cycles.
- R8: A write whose end is seen while `wrInhibit` is 1 is ignored.
- R9: During programming, a read returns bit 7 equal to the complement of bit 7 of the last byte loaded. Bit 6 starts at 0 and flips after each completed read. Bits 5..0 are 0.
- R10: Write cycles during programming are ignored.
- R11: After programming ends, reads return the array contents again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| busAddr | input | 15 | Byte address |
| busDataIn | input | 8 | Data driven by the host |
| busDataOut | output | 8 | Data driven by the device |
| busDataOe | output | 1 | Device drives the data bus when 1 |
| chipSelN | input | 1 | Active-low chip select |
| outEnN | input | 1 | Active-low output enable |
| wrEnN | input | 1 | Active-low write enable |
| wrInhibit | input | 1 | Blocks writes when 1 |

## Verification
Page programming is tried with four kinds of stimulus:
- A single byte, which shows that programming waits for the load window and leaves its neighbours untouched.
- A multi-byte load that mixes both strobe orderings and rewrites one slot, which separates last-value-wins from first-value-wins and tells buffered bytes from unloaded ones.
- A load that strays into a second page, and writes blocked by the inhibit input, by output enable, or by a busy array. These must all leave the array erased, which tells rejection apart from a partial commit.
- A cycle in which the address and data change between the two strobe edges, which shows whether capture follows the later fall and the earlier rise rather than a single strobe.

Back-to-back status reads during programming tell a correct complement and toggle pattern from a stale or a fixed one.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureAddr;  // write cycle opened: take address
    logic storeByte;    // write cycle closed and accepted
    logic firstByte;    // accepted byte opens a new page load
    logic dropBuf;      // discard page buffer contents
    logic commitEn;     // copy one buffer slot into the array
    logic readDone;     // a read cycle just ended
    logic progActive;   // programming in progress
  } ctrlStrobes_t;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int              WIDTH     = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RESET_VAL;
      q      <= RESET_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int PAGE_BYTES  = 64,
  parameter int LOAD_WINDOW = 40,
  parameter int PROG_CYCLES = 200
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ceS,
  input  logic                          oeS,
  input  logic                          weS,
  input  logic                          inhS,
  input  logic                          pageMatch,
  output ctrlStrobes_t                  st,
  output logic [$clog2(PAGE_BYTES)-1:0] commitIdx,
  output logic                          readMode
);

  localparam int PAW = $clog2(PAGE_BYTES);
  localparam int GW  = $clog2(LOAD_WINDOW + 1);
  localparam int PCW = $clog2(PROG_CYCLES + 1);

  engState_t      state;
  logic [GW-1:0]  gapCnt;
  logic [PCW-1:0] progCnt;
  logic           wrAct, wrActQ, rdAct, rdActQ;
  logic           wrStart, wrEnd, accept, progLast;

  assign wrAct    = !ceS && !weS && oeS;
  assign rdAct    = !ceS && !oeS && weS;
  assign wrStart  = wrAct && !wrActQ;
  assign wrEnd    = !wrAct && wrActQ;
  assign accept   = wrEnd && !inhS && (state != ST_PROG);
  assign progLast = (state == ST_PROG) && (progCnt == PCW'(PROG_CYCLES - 1));
  assign readMode = rdAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      gapCnt  <= '0;
      progCnt <= '0;
      wrActQ  <= 1'b0;
      rdActQ  <= 1'b0;
    end else begin
      wrActQ <= wrAct;
      rdActQ <= rdAct;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_LOAD;
            gapCnt <= '0;
          end
        end
        ST_LOAD: begin
          if (accept && !pageMatch) begin
            state <= ST_IDLE;
          end else if (accept || wrAct) begin
            gapCnt <= '0;
          end else if (gapCnt == GW'(LOAD_WINDOW - 1)) begin
            state   <= ST_PROG;
            progCnt <= '0;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (progLast) state <= ST_IDLE;
          else          progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    st             = '0;
    st.captureAddr = wrStart;
    st.firstByte   = (state == ST_IDLE);
    st.storeByte   = accept && ((state == ST_IDLE) || pageMatch);
    st.dropBuf     = (accept && (state == ST_LOAD) && !pageMatch) || progLast;
    st.commitEn    = (state == ST_PROG) && (int'(progCnt) < PAGE_BYTES);
    st.readDone    = !rdAct && rdActQ;
    st.progActive  = (state == ST_PROG);
  end

  assign commitIdx = progCnt[PAW-1:0];

endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int ARRAY_BYTES = 2048
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  st,
  input  logic [$clog2(PAGE_BYTES)-1:0] commitIdx,
  input  logic [ADDR_W-1:0]             addrS,
  input  logic [DATA_W-1:0]             dataS,
  output logic                          pageMatch,
  output logic [DATA_W-1:0]             readData
);

  localparam int PAW = $clog2(PAGE_BYTES);
  localparam int ARW = $clog2(ARRAY_BYTES);
  localparam int PGW = ADDR_W - PAW;

  logic [ADDR_W-1:0]     addrLatch;
  logic [PGW-1:0]        bufPage;
  logic [DATA_W-1:0]     bufData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic                  lastMsb;
  logic                  toggleQ;
  logic [DATA_W-1:0]     mem [ARRAY_BYTES];
  logic [PAW-1:0]        slot;

  assign slot      = addrLatch[PAW-1:0];
  assign pageMatch = (addrLatch[ADDR_W-1:PAW] == bufPage);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
      bufPage   <= '0;
      bufValid  <= '0;
      lastMsb   <= 1'b0;
      toggleQ   <= 1'b0;
    end else begin
      if (st.captureAddr) addrLatch <= addrS;
      if (st.dropBuf) begin
        bufValid <= '0;
      end else if (st.storeByte) begin
        if (st.firstByte) begin
          bufValid <= '0;
          bufPage  <= addrLatch[ADDR_W-1:PAW];
        end
        bufValid[slot] <= 1'b1;
        lastMsb        <= dataS[DATA_W-1];
      end
      if (!st.progActive)   toggleQ <= 1'b0;
      else if (st.readDone) toggleQ <= ~toggleQ;
    end
  end

  always_ff @(posedge clk) begin
    if (st.storeByte) bufData[slot] <= dataS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= '1;
    end else if (st.commitEn && bufValid[commitIdx]) begin
      mem[ARW'({bufPage, commitIdx})] <= bufData[commitIdx];
    end
  end

  always_comb begin
    if (st.progActive) readData = {~lastMsb, toggleQ, {(DATA_W-2){1'b0}}};
    else               readData = mem[ARW'(addrS)];
  end

endmodule

// File: rtl/eep_page_device.sv
module eep_page_device
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int ARRAY_BYTES = 2048,
  parameter int LOAD_WINDOW = 40,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic              chipSelN,
  input  logic              outEnN,
  input  logic              wrEnN,
  input  logic              wrInhibit
);

  localparam int PAW = $clog2(PAGE_BYTES);
  localparam int BW  = ADDR_W + DATA_W;

  logic [3:0]        ctlS;
  logic [BW-1:0]     busS;
  ctrlStrobes_t      st;
  logic [PAW-1:0]    commitIdx;
  logic              pageMatch;

  eep_sync #(.WIDTH(4), .RESET_VAL(4'b0111)) i_ctlSync (
    .clk (clk),
    .rstN(rstN),
    .d   ({wrInhibit, wrEnN, outEnN, chipSelN}),
    .q   (ctlS)
  );

  eep_sync #(.WIDTH(BW), .RESET_VAL('0)) i_busSync (
    .clk (clk),
    .rstN(rstN),
    .d   ({busAddr, busDataIn}),
    .q   (busS)
  );

  eep_ctrl #(
    .PAGE_BYTES (PAGE_BYTES),
    .LOAD_WINDOW(LOAD_WINDOW),
    .PROG_CYCLES(PROG_CYCLES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceS      (ctlS[0]),
    .oeS      (ctlS[1]),
    .weS      (ctlS[2]),
    .inhS     (ctlS[3]),
    .pageMatch(pageMatch),
    .st       (st),
    .commitIdx(commitIdx),
    .readMode (busDataOe)
  );

  eep_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES),
    .ARRAY_BYTES(ARRAY_BYTES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .commitIdx(commitIdx),
    .addrS    (busS[BW-1:DATA_W]),
    .dataS    (busS[DATA_W-1:0]),
    .pageMatch(pageMatch),
    .readData (busDataOut)
  );

endmodule

// File: rtl/eep_page_device_chk.sv
module eep_page_device_chk #(
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 200
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipSelN,
  input logic              outEnN,
  input logic              wrEnN,
  input logic              wrInhibit,
  input logic [DATA_W-1:0] busDataOut,
  input logic              busDataOe,
  input logic              progActive,
  input logic              storeByte
);

  int progLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           progLen <= 0;
    else if (progActive) progLen <= progLen + 1;
    else                 progLen <= 0;
  end

  assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!chipSelN && !outEnN && wrEnN, 2) |-> busDataOe);

  assert_hiz_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chipSelN, 2) || $past(outEnN, 2)) |-> !busDataOe);

  assert_prog_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progActive) |-> (progLen == PROG_CYCLES));

  assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rstN)
    storeByte |-> !$past(wrInhibit, 2));

  assert_status_steady_R9: assert property (@(posedge clk) disable iff (!rstN)
    (progActive && $past(progActive) && busDataOe && $past(busDataOe)) |-> $stable(busDataOut));

endmodule

bind eep_page_device eep_page_device_chk #(
  .DATA_W     (DATA_W),
  .PROG_CYCLES(PROG_CYCLES)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chipSelN  (chipSelN),
  .outEnN    (outEnN),
  .wrEnN     (wrEnN),
  .wrInhibit (wrInhibit),
  .busDataOut(busDataOut),
  .busDataOe (busDataOe),
  .progActive(st.progActive),
  .storeByte (st.storeByte)
);

// File: tb/test_eep_page_device.sv
`timescale 1ns/1ps
module test_eep_page_device;

  localparam int LOAD_WINDOW = 40;
  localparam int PROG_CYCLES = 200;
  localparam int SETTLE      = LOAD_WINDOW + PROG_CYCLES + 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] busAddr = '0;
  logic [7:0]  busDataIn = '0;
  logic [7:0]  busDataOut;
  logic        busDataOe;
  logic        chipSelN = 1'b1;
  logic        outEnN = 1'b1;
  logic        wrEnN = 1'b1;
  logic        wrInhibit = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  eep_page_device #(
    .LOAD_WINDOW(LOAD_WINDOW),
    .PROG_CYCLES(PROG_CYCLES)
  ) i_eep_page_device (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .chipSelN(chipSelN),
    .outEnN(outEnN), .wrEnN(wrEnN), .wrInhibit(wrInhibit)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic readByte(input logic [14:0] a, output logic [7:0] d, output logic oe);
    busAddr  = a;
    chipSelN = 1'b0;
    outEnN   = 1'b0;
    cyc(4);
    d  = busDataOut;
    oe = busDataOe;
    outEnN   = 1'b1;
    chipSelN = 1'b1;
    cyc(3);
  endtask

  task automatic expectRead(input string req, input logic [14:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic       oe;
    readByte(a, d, oe);
    check8(req, "read enable", {7'b0, oe}, 8'h01);
    check8(req, $sformatf("read @%h", a), d, exp);
  endtask

  // ceCtrl=0: write-enable strobe inside chip select; 1: chip select inside write enable
  task automatic writeByte(input logic [14:0] a, input logic [7:0] d, input bit ceCtrl);
    busAddr   = a;
    busDataIn = d;
    if (!ceCtrl) begin
      chipSelN = 1'b0; cyc(2);
      wrEnN    = 1'b0; cyc(3);
      wrEnN    = 1'b1; cyc(2);
      chipSelN = 1'b1; cyc(2);
    end else begin
      wrEnN    = 1'b0; cyc(2);
      chipSelN = 1'b0; cyc(3);
      chipSelN = 1'b1; cyc(2);
      wrEnN    = 1'b1; cyc(2);
    end
  endtask

  task automatic test_reset();
    check8("R2", "oe after reset", {7'b0, busDataOe}, 8'h00);
    expectRead("R1", 15'h0000, 8'hFF);
  endtask

  task automatic test_hiz();
    chipSelN = 1'b0; outEnN = 1'b1; cyc(4);
    check8("R2", "oe with output enable high", {7'b0, busDataOe}, 8'h00);
    chipSelN = 1'b1; outEnN = 1'b0; cyc(4);
    check8("R2", "oe with chip select high", {7'b0, busDataOe}, 8'h00);
    outEnN = 1'b1; cyc(3);
  endtask

  task automatic test_single();
    writeByte(15'h0105, 8'h3C, 1'b0);
    expectRead("R7", 15'h0105, 8'hFF);  // inside load window: not yet programmed
    cyc(SETTLE);
    expectRead("R5", 15'h0105, 8'h3C);
    expectRead("R5", 15'h0104, 8'hFF);
  endtask

  task automatic test_page();
    writeByte(15'h0200, 8'h11, 1'b0);
    writeByte(15'h0201, 8'h22, 1'b1);
    writeByte(15'h0202, 8'h33, 1'b0);
    writeByte(15'h023F, 8'h44, 1'b1);
    writeByte(15'h0201, 8'h99, 1'b0);
    cyc(SETTLE);
    expectRead("R5", 15'h0200, 8'h11);
    expectRead("R5", 15'h0201, 8'h99);
    expectRead("R5", 15'h0202, 8'h33);
    expectRead("R5", 15'h023F, 8'h44);
    expectRead("R5", 15'h0203, 8'hFF);
  endtask

  task automatic test_poll();
    writeByte(15'h0400, 8'hA5, 1'b0);
    cyc(LOAD_WINDOW + 10);
    expectRead("R9", 15'h0400, 8'h00);  // ~bit7=0, toggle 0
    expectRead("R9", 15'h0400, 8'h40);  // toggle flipped
    expectRead("R9", 15'h0400, 8'h00);
    writeByte(15'h0401, 8'h11, 1'b0);  // during programming
    cyc(SETTLE);
    expectRead("R11", 15'h0400, 8'hA5);
    expectRead("R10", 15'h0401, 8'hFF);
    writeByte(15'h0480, 8'h15, 1'b1);
    cyc(LOAD_WINDOW + 10);
    expectRead("R9", 15'h0480, 8'h80);
    cyc(SETTLE);
    expectRead("R11", 15'h0480, 8'h15);
  endtask

  task automatic test_mismatch();
    writeByte(15'h0600, 8'h12, 1'b0);
    writeByte(15'h0640, 8'h34, 1'b0);
    cyc(SETTLE);
    expectRead("R6", 15'h0600, 8'hFF);
    expectRead("R6", 15'h0640, 8'hFF);
  endtask

  task automatic test_inhibit();
    wrInhibit = 1'b1; cyc(3);
    writeByte(15'h0700, 8'h55, 1'b0);
    cyc(3);
    wrInhibit = 1'b0;
    cyc(SETTLE);
    expectRead("R8", 15'h0700, 8'hFF);
  endtask

  task automatic test_oe_low();
    busAddr = 15'h0900; busDataIn = 8'h5A;
    outEnN = 1'b0; chipSelN = 1'b0; cyc(2);
    wrEnN = 1'b0; cyc(4);
    check8("R3", "oe while write enable low", {7'b0, busDataOe}, 8'h00);
    wrEnN = 1'b1; cyc(2);
    chipSelN = 1'b1; outEnN = 1'b1; cyc(2);
    cyc(SETTLE);
    expectRead("R3", 15'h0900, 8'hFF);
  endtask

  task automatic test_edges();
    busAddr = 15'h0810; busDataIn = 8'h66;
    wrEnN = 1'b0; cyc(2);            // first fall
    busAddr = 15'h0820; cyc(2);
    chipSelN = 1'b0; cyc(3);         // last fall: address taken
    chipSelN = 1'b1; cyc(2);         // first rise: data taken
    busDataIn = 8'h77; cyc(1);
    wrEnN = 1'b1; cyc(2);
    cyc(SETTLE);
    expectRead("R4", 15'h0820, 8'h66);
    expectRead("R4", 15'h0810, 8'hFF);
  endtask

  bit done = 1'b0;

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(3);
    test_reset();
    test_hiz();
    test_single();
    test_page();
    test_poll();
    test_mismatch();
    test_inhibit();
    test_oe_low();
    test_edges();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule